// File: doc/BRIEF.md
# Serial Control Register Bank for a Clock Generator

This block is a two-wire serial slave that holds the six byte-wide control registers of a clock generator: frequency selection, spread-spectrum settings and one enable bit per clock output. The neighbouring gating and frequency-select logic reads the registers from a flat output bus. The latched power-up strap pins come in on a separate input and appear as read-only bits inside the registers.

There is no register pointer. A write transfer carries the address byte, then two bytes whose values are ignored (a command code and a byte count), then data bytes that go to register 0, 1, 2 and onward until the stop condition. A read transfer returns register 0 first and keeps counting up until the master stops. SCL and SDA are sampled by the system clock through two-flop synchronisers. The open-drain pad sits outside the block, which supplies only an active-high pull-low enable for SDA.

Top module: `clkcfg_serial_regs`

## Requirements
- R1: The block answers only the 7-bit address 0x69 (address byte 0xD2 for a write, 0xD3 for a read). For any other address it gives no acknowledge and leaves SDA released until the next start condition.
- R2: A start condition (SDA falling while SCL is high) begins a new transfer from any state, including a repeated start inside a transfer. A stop condition (SDA rising while SCL is high) ends the transfer.
- R3: In a write, the two bytes after the address are acknowledged and do not change any register. Each later byte is acknowledged and stored into register 0, then 1, then 2 and onward.
- R4: In a read, the block sends register 0, then 1, then 2 and onward, MSB first. A master NACK ends the transmission and releases SDA.
- R5: After reset, register 0 holds 0x00 and registers 1 to 5 hold 0xFF in every writable bit.
- R6: Four bits show the strap input strap_fs[3:0] and ignore writes: register 1 bit 7 = strap_fs[2], register 3 bit 6 = strap_fs[0], register 4 bit 3 = strap_fs[1], register 4 bit 1 = strap_fs[3].
- R7: Write bytes beyond register 5 are acknowledged and discarded. Read bytes beyond register 5 return 0xFF.
- R8: The block drives SDA low for the ninth clock of each byte it accepts, and it changes sda_oe only while SCL is low.
- R9: Register k appears on reg_bank[8k+7:8k], with the strap bits already placed in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock as seen at the pad |
| sda_in | input | 1 | Serial data as seen at the pad |
| strap_fs | input | 4 | Frequency-select straps latched at power-up |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_bank | output | 48 | All six registers, register 0 in the low byte |

## Verification
The hardest cases to reach from the ports are the pointer running past the last register and a repeated start that turns a half-finished write into a read. The stimulus sends a write with seven data bytes, then reads eight bytes, so both over-range paths are exercised. It then opens a short write, issues a new start without a stop, and reads back register 0. The strap bits are set to a mixed pattern, so a write of zeros or ones into the read-only positions shows up as a mismatch on every clock.

// File: rtl/clkcfg_serial_regs.sv
module clkcfg_serial_regs #(
  parameter logic [6:0] SLAVE_ADDR = 7'h69,
  parameter int         NREG       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [3:0]        strap_fs,
  output logic              sda_oe,
  output logic [NREG*8-1:0] reg_bank
);
  localparam int PW = $clog2(NREG + 1);
  localparam logic [PW-1:0] LAST = PW'(NREG);

  typedef enum logic [2:0] {IDLE, RX, RACK, TX, TACK} st_t;

  logic [2:0] scl_q, sda_q;
  logic [NREG-1:0][7:0] store, view;
  logic [7:0] sh, rd_byte;
  logic [3:0] bitcnt;
  logic [1:0] phase;
  logic [PW-1:0] ptr;
  logic rw;
  st_t st;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end

  wire scl_rise  = scl_q[1] & ~scl_q[2];
  wire scl_fall  = ~scl_q[1] & scl_q[2];
  wire start_det = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  wire stop_det  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];

  always_comb begin
    view = store;
    view[1][7] = strap_fs[2];
    view[3][6] = strap_fs[0];
    view[4][3] = strap_fs[1];
    view[4][1] = strap_fs[3];
  end

  assign reg_bank = view;
  assign rd_byte  = (ptr < LAST) ? view[ptr] : 8'hFF;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= IDLE;
      sda_oe <= 1'b0;
      sh     <= '0;
      bitcnt <= '0;
      phase  <= '0;
      ptr    <= '0;
      rw     <= 1'b0;
      for (int i = 0; i < NREG; i++) store[i] <= (i == 0) ? 8'h00 : 8'hFF;
    end else if (start_det) begin
      st     <= RX;
      sda_oe <= 1'b0;
      bitcnt <= '0;
      phase  <= '0;
      ptr    <= '0;
    end else if (stop_det) begin
      st     <= IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        RX:
          if (scl_rise && bitcnt != 4'd8) begin
            sh     <= {sh[6:0], sda_q[1]};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            bitcnt <= '0;
            if (phase == 2'd0 && sh[7:1] != SLAVE_ADDR) st <= IDLE;
            else begin
              st     <= RACK;
              sda_oe <= 1'b1;
              if (phase == 2'd0) rw <= sh[0];
              if (phase == 2'd3) begin
                if (ptr < LAST) store[ptr] <= sh;
                if (ptr != LAST) ptr <= ptr + 1'b1;
              end
            end
          end
        RACK:
          if (scl_fall) begin
            if (phase == 2'd0 && rw) begin
              st     <= TX;
              sh     <= {rd_byte[6:0], 1'b0};
              sda_oe <= ~rd_byte[7];
              bitcnt <= 4'd1;
              if (ptr != LAST) ptr <= ptr + 1'b1;
            end else begin
              st     <= RX;
              sda_oe <= 1'b0;
              if (phase != 2'd3) phase <= phase + 2'd1;
            end
          end
        TX:
          if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
              st     <= TACK;
            end else begin
              sda_oe <= ~sh[7];
              sh     <= {sh[6:0], 1'b0};
              bitcnt <= bitcnt + 4'd1;
            end
          end
        TACK:
          if (scl_rise && sda_q[1]) st <= IDLE;
          else if (scl_fall) begin
            st     <= TX;
            sh     <= {rd_byte[6:0], 1'b0};
            sda_oe <= ~rd_byte[7];
            bitcnt <= 4'd1;
            if (ptr != LAST) ptr <= ptr + 1'b1;
          end
        default: ;
      endcase
    end

  assert_sda_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

  assert_store_on_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(store) |-> $past(scl_fall && st == RX && phase == 2'd3));

  assert_tx_needs_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TX || st == TACK) |-> rw);

  assert_ptr_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST);
endmodule

// File: tb/clkcfg_serial_regs_test.sv
module clkcfg_serial_regs_test;
  localparam int H = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [3:0] strap = 4'b1010;
  logic sda_oe;
  logic [47:0] reg_bank;
  wire bus_sda = m_sda & ~sda_oe;

  int checks = 0, fails = 0;
  bit hold = 1'b1, done = 1'b0;
  logic [7:0] mreg [6];
  int mptr = 0;

  always #4 clk = ~clk;

  clkcfg_serial_regs uut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(bus_sda),
    .strap_fs(strap), .sda_oe(sda_oe), .reg_bank(reg_bank));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] wmask(input int i);
    case (i)
      1: return 8'h7F;
      3: return 8'hBF;
      4: return 8'hF5;
      default: return 8'hFF;
    endcase
  endfunction

  // R9 layout checked against the model on every clock (R5, R6, R3, R7)
  always @(negedge clk)
    if (rst_n && !hold)
      for (int i = 0; i < 6; i++)
        chk(reg_bank[8*i +: 8] === mreg[i], "R9_regs", reg_bank[8*i +: 8], mreg[i]);

  // R8: sda_oe must not change while SCL stays high
  logic prev_scl = 1'b1, prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && m_scl && prev_scl && !done)
      chk(sda_oe === prev_oe, "R8_oe_while_scl_high", sda_oe, prev_oe);
    prev_scl <= m_scl;
    prev_oe  <= sda_oe;
  end

  task automatic bus_start;
    m_sda = 1; tick(H); m_scl = 1; tick(H); m_sda = 0; tick(H); m_scl = 0; tick(H);
  endtask

  task automatic bus_stop;
    m_sda = 0; tick(H); m_scl = 1; tick(H); m_sda = 1; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input bit data, input string req);
    logic got;
    if (data) hold = 1;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(H); m_scl = 1; tick(H); m_scl = 0; tick(2);
    end
    m_sda = 1; tick(H); m_scl = 1; tick(H/2);
    got = (bus_sda == 1'b0);
    chk(got == exp_ack, req, got, exp_ack);
    tick(H/2); m_scl = 0; tick(H);
    if (data) begin
      if (mptr < 6) mreg[mptr] = (b & wmask(mptr)) | (mreg[mptr] & ~wmask(mptr));
      mptr++;
      hold = 0;
    end
  endtask

  task automatic recv_byte(input logic [7:0] exp, input bit mack, input string req);
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1; tick(H); m_scl = 1; tick(H/2);
      got[i] = bus_sda;
      tick(H/2); m_scl = 0; tick(2);
    end
    chk(got === exp, req, got, exp);
    m_sda = mack ? 1'b0 : 1'b1; tick(H); m_scl = 1; tick(H); m_scl = 0; tick(2); m_sda = 1;
  endtask

  function automatic logic [7:0] exp_rd(input int i);
    return (i < 6) ? mreg[i] : 8'hFF;
  endfunction

  initial begin
    mreg[0] = 8'h00; mreg[1] = 8'h7F; mreg[2] = 8'hFF;
    mreg[3] = 8'hBF; mreg[4] = 8'hFF; mreg[5] = 8'hFF;
    tick(5); rst_n = 1; tick(2);
    // R5 / R6 reset image with straps 1010
    chk(reg_bank === 48'hFF_FF_BF_FF_7F_00, "R5_reset", 0, 0);
    chk(sda_oe === 1'b0, "R5_reset_oe", sda_oe, 0);
    hold = 0;

    // R1 R3 R7: write 7 data bytes after two ignored bytes
    bus_start;
    send_byte(8'hD2, 1, 0, "R1_addr_write");
    send_byte(8'h00, 1, 0, "R3_cmd_ack");
    send_byte(8'hFF, 1, 0, "R3_count_ack");
    mptr = 0;
    send_byte(8'h8B, 1, 1, "R3_data0");
    send_byte(8'h12, 1, 1, "R6_data1");
    send_byte(8'h34, 1, 1, "R3_data2");
    send_byte(8'h00, 1, 1, "R6_data3");
    send_byte(8'h00, 1, 1, "R6_data4");
    send_byte(8'h5A, 1, 1, "R3_data5");
    send_byte(8'h77, 1, 1, "R7_write_past_end");
    bus_stop;

    // R4 R7: read from register 0 past the end
    bus_start;
    send_byte(8'hD3, 1, 0, "R1_addr_read");
    for (int i = 0; i < 8; i++) recv_byte(exp_rd(i), i != 7, "R4_R7_read");
    chk(sda_oe === 1'b0, "R4_nack_release", sda_oe, 0);
    bus_stop;

    // R1: wrong address ignored
    bus_start;
    send_byte(8'hA0, 0, 0, "R1_no_ack");
    send_byte(8'h00, 0, 0, "R1_ignored");
    send_byte(8'h00, 0, 0, "R1_ignored");
    send_byte(8'h00, 0, 0, "R1_ignored");
    bus_stop;

    // R2: short write, then repeated start into a read
    bus_start;
    send_byte(8'hD2, 1, 0, "R2_addr");
    send_byte(8'h11, 1, 0, "R2_cmd");
    send_byte(8'h22, 1, 0, "R2_count");
    mptr = 0;
    send_byte(8'h01, 1, 1, "R2_data0");
    bus_start;
    send_byte(8'hD3, 1, 0, "R2_restart_read");
    recv_byte(exp_rd(0), 1, "R2_read0");
    recv_byte(exp_rd(1), 0, "R2_read1");
    bus_stop;

    // R3: only the two ignored bytes, nothing changes
    bus_start;
    send_byte(8'hD2, 1, 0, "R3_addr");
    send_byte(8'h55, 1, 0, "R3_cmd_only");
    send_byte(8'hAA, 1, 0, "R3_count_only");
    bus_stop;
    tick(20);
    chk(reg_bank[7:0] === 8'h01, "R3_no_change", reg_bank[7:0], 8'h01);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule